// File: doc/BRIEF.md
# Opcode-Driven Integer ALU

This block is the arithmetic and logic unit of a small non-pipelined core. It decodes the core's 4-bit opcode directly and works on two 16-bit operands. For each operation it produces a 16-bit result, a zero indication and a valid bit that says whether the opcode was an ALU operation. Opcodes that do something else in the core, such as loads, jumps and halt, pass through it harmlessly: the result is zero and valid is low.

With the default build, the result, zero and valid outputs are registered. They appear one clock after the opcode and operands are presented, and a synchronous active-high reset clears them. Setting a parameter builds a purely combinational variant with the same function. The core can latch the zero output as its branch condition.

Top module: `opalu_core`

## Requirements
- R1: Opcode 1 gives op0 + op1, truncated to 16 bits (modulo 2^16).
- R2: Opcode 2 gives op0 - op1, modulo 2^16.
- R3: Opcode 3 gives the low 16 bits of the unsigned product op0 * op1.
- R4: Opcode 4 gives op1 shifted right logically by one bit, with bit 15 filled with zero. The value of op0 does not affect the result.
- R5: Opcode 6 gives op0 AND op1, opcode 7 gives op0 OR op1, and opcode 8 gives op0 XOR op1.
- R6: The zero output is 1 exactly when the 16-bit result output is 0x0000.
- R7: Opcodes 0, 5 and 9 through 15 drive result to 0x0000 and valid to 0, for any operand values. Because the result is zero, zero reads 1.
- R8: valid is 1 for opcodes 1, 2, 3, 4, 6, 7 and 8.
- R9: In the registered build, the outputs change only on a rising clock edge. They reflect the inputs sampled at that edge. While reset is high, a clock edge sets result to 0x0000, zero to 1 and valid to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| opcode | input | 4 | Core opcode |
| op0 | input | 16 | First operand |
| op1 | input | 16 | Second operand (the only operand used by the shift) |
| result | output | 16 | Operation result |
| zero | output | 1 | High when result is zero |
| valid | output | 1 | High when the opcode was an ALU operation |

## Verification
Some properties are checked on every cycle. Zero must agree with the result. A low valid must come with a zero result. Valid must match the opcode sampled one edge earlier. Add and shift results must follow the previous cycle's operands.

The bench scenarios cover the rest. These are:
- the wrap-around values of subtract and multiply;
- the bitwise operations;
- the shift ignoring op0 and filling the top bit with zero;
- the full set of non-ALU opcodes;
- the reset values.

A separate scenario checks that the outputs hold between edges.

// File: rtl/opalu_pkg.sv
package opalu_pkg;
  localparam int OPC_W = 4;

  typedef enum logic [OPC_W-1:0] {
    OPC_NOP = 4'd0,
    OPC_ADD = 4'd1,
    OPC_SUB = 4'd2,
    OPC_MUL = 4'd3,
    OPC_SHR = 4'd4,
    OPC_AND = 4'd6,
    OPC_OR  = 4'd7,
    OPC_XOR = 4'd8
  } opc_e;

  typedef struct packed {
    logic add;
    logic sub;
    logic mul;
    logic shr;
    logic band;
    logic bor;
    logic bxor;
  } sel_t;

  function automatic logic is_alu_op(input logic [OPC_W-1:0] op);
    return (op == OPC_ADD) || (op == OPC_SUB) || (op == OPC_MUL) ||
           (op == OPC_SHR) || (op == OPC_AND) || (op == OPC_OR)  ||
           (op == OPC_XOR);
  endfunction
endpackage

// File: rtl/opalu_decode.sv
module opalu_decode
  import opalu_pkg::*;
(
  input  logic [OPC_W-1:0] opcode,
  output sel_t             sel,
  output logic             is_op
);
  always_comb begin
    sel = '0;
    case (opcode)
      OPC_ADD: sel.add  = 1'b1;
      OPC_SUB: sel.sub  = 1'b1;
      OPC_MUL: sel.mul  = 1'b1;
      OPC_SHR: sel.shr  = 1'b1;
      OPC_AND: sel.band = 1'b1;
      OPC_OR:  sel.bor  = 1'b1;
      OPC_XOR: sel.bxor = 1'b1;
      default: sel = '0;
    endcase
  end

  assign is_op = |sel;
endmodule

// File: rtl/opalu_datapath.sv
module opalu_datapath
  import opalu_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  sel_t              sel,
  input  logic [DATA_W-1:0] a,
  input  logic [DATA_W-1:0] b,
  output logic [DATA_W-1:0] y
);
  logic [DATA_W-1:0] sum, dif, prod, shr, v_and, v_or, v_xor;

  assign sum   = a + b;
  assign dif   = a - b;
  assign prod  = a * b;
  assign shr   = {1'b0, b[DATA_W-1:1]};
  assign v_and = a & b;
  assign v_or  = a | b;
  assign v_xor = a ^ b;

  // one-hot select, AND-OR merge keeps the mux shallow
  assign y = ({DATA_W{sel.add}}  & sum)   |
             ({DATA_W{sel.sub}}  & dif)   |
             ({DATA_W{sel.mul}}  & prod)  |
             ({DATA_W{sel.shr}}  & shr)   |
             ({DATA_W{sel.band}} & v_and) |
             ({DATA_W{sel.bor}}  & v_or)  |
             ({DATA_W{sel.bxor}} & v_xor);
endmodule

// File: rtl/opalu_stage.sv
module opalu_stage #(
  parameter int DATA_W  = 16,
  parameter bit REG_OUT = 1'b1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [DATA_W-1:0] d_result,
  input  logic              d_valid,
  output logic [DATA_W-1:0] result,
  output logic              zero,
  output logic              valid
);
  logic d_zero;
  assign d_zero = (d_result == '0);

  if (REG_OUT) begin : g_reg
    always_ff @(posedge clk) begin
      if (rst) begin
        result <= '0;
        zero   <= 1'b1;
        valid  <= 1'b0;
      end else begin
        result <= d_result;
        zero   <= d_zero;
        valid  <= d_valid;
      end
    end
  end else begin : g_comb
    assign result = d_result;
    assign zero   = d_zero;
    assign valid  = d_valid;
  end
endmodule

// File: rtl/opalu_core.sv
module opalu_core
  import opalu_pkg::*;
#(
  parameter int DATA_W  = 16,
  parameter bit REG_OUT = 1'b1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [OPC_W-1:0]  opcode,
  input  logic [DATA_W-1:0] op0,
  input  logic [DATA_W-1:0] op1,
  output logic [DATA_W-1:0] result,
  output logic              zero,
  output logic              valid
);
  sel_t              sel;
  logic              is_op;
  logic [DATA_W-1:0] y;

  opalu_decode u_dec (
    .opcode (opcode),
    .sel    (sel),
    .is_op  (is_op)
  );

  opalu_datapath #(.DATA_W(DATA_W)) u_dp (
    .sel (sel),
    .a   (op0),
    .b   (op1),
    .y   (y)
  );

  opalu_stage #(.DATA_W(DATA_W), .REG_OUT(REG_OUT)) u_stg (
    .clk      (clk),
    .rst      (rst),
    .d_result (y),
    .d_valid  (is_op),
    .result   (result),
    .zero     (zero),
    .valid    (valid)
  );
endmodule

// File: rtl/opalu_chk.sv
module opalu_chk
  import opalu_pkg::*;
#(
  parameter int DATA_W  = 16,
  parameter bit REG_OUT = 1'b1
) (
  input logic              clk,
  input logic              rst,
  input logic [OPC_W-1:0]  opcode,
  input logic [DATA_W-1:0] op0,
  input logic [DATA_W-1:0] op1,
  input logic [DATA_W-1:0] result,
  input logic              zero,
  input logic              valid
);
  logic live;
  always_ff @(posedge clk) live <= !rst;

  p_zero_match_r6: assert property (@(posedge clk) disable iff (rst)
    zero == (result == '0));

  p_invalid_zero_r7: assert property (@(posedge clk) disable iff (rst)
    !valid |-> (result == '0));

  if (REG_OUT) begin : g_reg
    p_valid_map_r8: assert property (@(posedge clk) disable iff (rst)
      live |-> (valid == is_alu_op($past(opcode))));

    p_add_wrap_r1: assert property (@(posedge clk) disable iff (rst)
      (live && $past(opcode) == OPC_ADD) |-> (result == $past(op0) + $past(op1)));

    p_shift_r4: assert property (@(posedge clk) disable iff (rst)
      (live && $past(opcode) == OPC_SHR) |-> (result == ($past(op1) >> 1)));
  end else begin : g_comb
    p_valid_map_r8: assert property (@(posedge clk) disable iff (rst)
      valid == is_alu_op(opcode));

    p_add_wrap_r1: assert property (@(posedge clk) disable iff (rst)
      (opcode == OPC_ADD) |-> (result == op0 + op1));

    p_shift_r4: assert property (@(posedge clk) disable iff (rst)
      (opcode == OPC_SHR) |-> (result == (op1 >> 1)));
  end
endmodule

bind opalu_core opalu_chk #(.DATA_W(DATA_W), .REG_OUT(REG_OUT)) u_chk (.*);

// File: tb/sim_opalu_core.sv
module sim_opalu_core;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [3:0]  opcode = 4'd0;
  logic [15:0] op0 = '0;
  logic [15:0] op1 = '0;
  logic [15:0] result;
  logic        zero;
  logic        valid;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #5 clk = ~clk;

  opalu_core u0 (
    .clk(clk), .rst(rst), .opcode(opcode), .op0(op0), .op1(op1),
    .result(result), .zero(zero), .valid(valid)
  );

  task automatic check(input string tag, input logic [15:0] got, input logic [15:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  function automatic logic [15:0] ref_res(input logic [3:0] op, input logic [15:0] a, input logic [15:0] b);
    logic [31:0] p;
    p = a * b;
    case (op)
      4'd1: return 16'(a + b);
      4'd2: return 16'(a - b);
      4'd3: return p[15:0];
      4'd4: return {1'b0, b[15:1]};
      4'd6: return a & b;
      4'd7: return a | b;
      4'd8: return a ^ b;
      default: return 16'h0000;
    endcase
  endfunction

  function automatic logic ref_valid(input logic [3:0] op);
    return (op inside {4'd1, 4'd2, 4'd3, 4'd4, 4'd6, 4'd7, 4'd8});
  endfunction

  // drive at a falling edge, let one rising edge register, sample at the next falling edge
  task automatic apply(input logic [3:0] op, input logic [15:0] a, input logic [15:0] b);
    @(negedge clk);
    opcode = op; op0 = a; op1 = b;
    @(negedge clk);
  endtask

  task automatic run_op(input string tag, input logic [3:0] op, input logic [15:0] a, input logic [15:0] b);
    logic [15:0] e;
    e = ref_res(op, a, b);
    apply(op, a, b);
    check({tag, " result"}, result, e);
    check({tag, " zero R6"}, {15'd0, zero}, {15'd0, e == 16'h0});
    check({tag, " valid R8"}, {15'd0, valid}, {15'd0, ref_valid(op)});
  endtask

  task automatic t_reset;
    opcode = 4'd1; op0 = 16'h0005; op1 = 16'h0006;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R9 reset result", result, 16'h0000);
    check("R9 reset zero", {15'd0, zero}, 16'h0001);
    check("R9 reset valid", {15'd0, valid}, 16'h0000);
    rst = 1'b0;
  endtask

  task automatic t_add;
    run_op("R1 add small", 4'd1, 16'h0005, 16'h0006);
    run_op("R1 add wrap", 4'd1, 16'hFFFF, 16'h0001);
    run_op("R1 add big", 4'd1, 16'h8000, 16'h8001);
  endtask

  task automatic t_sub;
    run_op("R2 sub neg", 4'd2, 16'h0005, 16'h0007);
    run_op("R2 sub eq", 4'd2, 16'h1234, 16'h1234);
    run_op("R2 sub pos", 4'd2, 16'h9000, 16'h0001);
  endtask

  task automatic t_mul;
    run_op("R3 mul trunc", 4'd3, 16'h1234, 16'h0100);
    run_op("R3 mul max", 4'd3, 16'hFFFF, 16'hFFFF);
    run_op("R3 mul small", 4'd3, 16'h0007, 16'h0009);
    run_op("R3 mul lowzero", 4'd3, 16'h0100, 16'h0100);
  endtask

  task automatic t_shift;
    run_op("R4 shr top", 4'd4, 16'h0000, 16'h8001);
    run_op("R4 shr ones", 4'd4, 16'hFFFF, 16'hFFFF);
    apply(4'd4, 16'h1111, 16'h00F0);
    check("R4 shr op0 A", result, 16'h0078);
    apply(4'd4, 16'hEEEE, 16'h00F0);
    check("R4 shr op0 B", result, 16'h0078);
    run_op("R4 shr to zero", 4'd4, 16'hABCD, 16'h0001);
  endtask

  task automatic t_logic;
    run_op("R5 and", 4'd6, 16'hF0F0, 16'hFF00);
    run_op("R5 and zero", 4'd6, 16'hF0F0, 16'h0F0F);
    run_op("R5 or", 4'd7, 16'hF0F0, 16'h0F00);
    run_op("R5 xor", 4'd8, 16'hAAAA, 16'hFFFF);
    run_op("R5 xor self", 4'd8, 16'h5A5A, 16'h5A5A);
  endtask

  task automatic t_invalid;
    for (int k = 0; k < 16; k++) begin
      if (!ref_valid(4'(k))) begin
        apply(4'(k), 16'hFFFF, 16'h1234);
        check($sformatf("R7 op%0d result", k), result, 16'h0000);
        check($sformatf("R7 op%0d valid", k), {15'd0, valid}, 16'h0000);
        check($sformatf("R7 op%0d zero", k), {15'd0, zero}, 16'h0001);
      end
    end
  endtask

  task automatic t_valid;
    for (int k = 0; k < 16; k++) begin
      if (ref_valid(4'(k))) begin
        apply(4'(k), 16'h0003, 16'h0002);
        check($sformatf("R8 op%0d valid", k), {15'd0, valid}, 16'h0001);
      end
    end
  endtask

  task automatic t_latency;
    apply(4'd1, 16'h0001, 16'h0002);
    check("R9 first", result, 16'h0003);
    @(negedge clk);
    opcode = 4'd1; op0 = 16'h0004; op1 = 16'h0004;
    #2;
    check("R9 hold before edge", result, 16'h0003);
    @(negedge clk);
    check("R9 after edge", result, 16'h0008);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    t_reset;
    t_add;
    t_sub;
    t_mul;
    t_shift;
    t_logic;
    t_invalid;
    t_valid;
    t_latency;
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule